// File: doc/BRIEF.md
# Vectored Interrupt Acknowledge Responder

This block is the interrupt front end of a peripheral on an 8-bit bus. A pulse from the peripheral's own event logic latches a request. The block then pulls an active-low, level-type interrupt line to the processor. The processor answers with an acknowledge cycle, which is the only cycle in which its opcode-fetch strobe and its I/O-request strobe are low together. In that cycle, a responder that holds daisy-chain priority enables its vector byte onto the data bus. Software programs this vector, and it is always even. The request then moves into service.

The responder snoops every opcode fetch and looks for the two-byte return-from-interrupt sequence `ED 4D`. When that sequence arrives while the responder holds priority, the in-service state clears. The priority chain then reopens to lower-priority devices. The processor may stretch the acknowledge cycle with any number of wait states. The vector stays enabled for as long as both strobes stay low.

The controller has four states:
- `ST_IDLE`: nothing is pending.
- `ST_PEND`: the request is latched and the interrupt line is driven.
- `ST_ACK`: the vector is on the bus.
- `ST_SERV`: the handler is running.

Its transitions are:
- `evt_seen`: IDLE→PEND.
- `ack_won`: PEND→ACK.
- `ack_done`: ACK→SERV.
- `ret_idle`: SERV→IDLE.
- `ret_repend`: SERV→PEND, taken when an event arrived during ACK or SERV.

The return matcher has two states, `RM_IDLE` and `RM_PREFIX`. On a fetch of `ED` it moves `pfx_seen`. On a fetch of `4D` it reports `ret_hit`. On any other byte it moves `pfx_lost`.

Top module: `vec_irq_responder`

## Requirements
- R1: After reset, `int_n_o` is 1, `vec_oe_o` is 0 and `prio_out_o` follows `prio_in_i`.
- R2: A write through `vec_wr_i`/`vec_wdata_i` stores the byte with bit 0 forced to 0. The byte later appears on `vec_o` during an acknowledge, and `vec_o` is 0x00 whenever `vec_oe_o` is 0.
- R3: An `evt_i` pulse makes `int_n_o` low from the next clock. The line stays low until an acknowledge of this responder is recognized.
- R4: An acknowledge is recognized only when `m1_n_i` and `iorq_n_i` are both 0. Either strobe low alone never raises `vec_oe_o` and never clears the request.
- R5: During a recognized acknowledge with `prio_in_i` high and a pending request, `vec_oe_o` is 1 in the same cycle, and `int_n_o` returns to 1 from the following clock.
- R6: With `prio_in_i` low, an acknowledge is ignored: `vec_oe_o` stays 0 and `int_n_o` stays 0.
- R7: `vec_oe_o` stays 1 for every cycle that the acknowledge is stretched by wait states. It drops in the first cycle that either strobe is high.
- R8: `prio_out_o` is 1 only when `prio_in_i` is 1 and the responder has neither a pending nor an in-service interrupt.
- R9: While in service with `prio_in_i` high, opcode fetches of 0xED then 0x4D clear the in-service state. `prio_out_o` is then 1 again.
- R10: If any other fetched byte comes between 0xED and 0x4D, the return is not recognized and service continues.
- R11: A return sequence fetched while `prio_in_i` is low does not clear the in-service state.
- R12: An event that arrives during acknowledge or service is held. After the return it drives `int_n_o` low again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 1 | Request pulse from the peripheral function |
| vec_wr_i | input | 1 | Vector register write strobe |
| vec_wdata_i | input | 8 | Vector write data |
| m1_n_i | input | 1 | Opcode-fetch strobe, active low |
| iorq_n_i | input | 1 | I/O-request strobe, active low |
| bus_data_i | input | 8 | Data bus as seen by the responder (fetched opcodes) |
| prio_in_i | input | 1 | Daisy-chain priority enable in |
| prio_out_o | output | 1 | Daisy-chain priority enable out |
| int_n_o | output | 1 | Level interrupt request, active low |
| vec_o | output | 8 | Vector byte for the data bus |
| vec_oe_o | output | 1 | Tri-state enable for `vec_o` |

## Verification
The bench drives each strobe low on its own while a request is pending. A decoder that treats either strobe as an acknowledge would drive the bus during ordinary fetches or I/O cycles and lose the request. It stretches the acknowledge over several wait states, because a design that acts on a fixed-length window would release the bus early. It breaks the return sequence with a foreign byte, and a matcher that forgets to fall back to idle would end service on a stray 0x4D. It also sends the return while a higher-priority device holds the chain, where a design that ignores priority would end the wrong handler. Finally, it raises a second event during service, which a design without a held request would lose.

// File: rtl/vir_pkg.sv
package vir_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PEND = 2'd1,
        ST_ACK  = 2'd2,
        ST_SERV = 2'd3
    } irq_state_t;

    typedef enum logic {
        RM_IDLE   = 1'b0,
        RM_PREFIX = 1'b1
    } ret_state_t;
endpackage

// File: rtl/vir_vector_reg.sv
module vir_vector_reg #(
    parameter int VEC_W     = 8,
    parameter bit EVEN_ONLY = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [VEC_W-1:0] wdata_i,
    output logic [VEC_W-1:0] vec_o
);
    logic [VEC_W-1:0] vec_q;
    logic [VEC_W-1:0] vec_d;

    generate
        if (EVEN_ONLY) begin : g_even
            always_comb vec_d = {wdata_i[VEC_W-1:1], 1'b0};
        end else begin : g_any
            always_comb vec_d = wdata_i;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q <= '0;
        end else if (wr_i) begin
            vec_q <= vec_d;
        end
    end

    assign vec_o = vec_q;

    generate
        if (EVEN_ONLY) begin : g_chk
            // R2: the stored vector is always even
            assert_vec_even_R2: assert property (@(posedge clk) disable iff (!rst_n)
                wr_i |=> (vec_q[0] == 1'b0));
        end
    endgenerate
endmodule

// File: rtl/vir_ret_matcher.sv
module vir_ret_matcher
    import vir_pkg::*;
#(
    parameter int          DW      = 8,
    parameter logic [DW-1:0] PFX_OP = 8'hED,
    parameter logic [DW-1:0] RET_OP = 8'h4D
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          m1_n_i,
    input  logic          iorq_n_i,
    input  logic [DW-1:0] data_i,
    output logic          ret_hit_o
);
    ret_state_t st_q, st_d;
    logic fetch, fetch_q, fetch_start;

    // an opcode fetch is M1 low without an I/O request
    assign fetch       = !m1_n_i && iorq_n_i;
    assign fetch_start = fetch && !fetch_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= RM_IDLE;
            fetch_q <= 1'b0;
        end else begin
            st_q    <= st_d;
            fetch_q <= fetch;
        end
    end

    always_comb begin
        st_d      = st_q;
        ret_hit_o = 1'b0;
        if (fetch_start) begin
            unique case (st_q)
                RM_IDLE: begin
                    if (data_i == PFX_OP) st_d = RM_PREFIX;        // pfx_seen
                end
                RM_PREFIX: begin
                    if (data_i == RET_OP) begin
                        ret_hit_o = 1'b1;                          // ret_hit
                        st_d      = RM_IDLE;
                    end else if (data_i == PFX_OP) begin
                        st_d = RM_PREFIX;
                    end else begin
                        st_d = RM_IDLE;                            // pfx_lost
                    end
                end
                default: st_d = RM_IDLE;
            endcase
        end
    end

    // R10: a hit is always followed by the idle state
    assert_hit_returns_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ret_hit_o |=> (st_q == RM_IDLE));
endmodule

// File: rtl/vir_irq_fsm.sv
module vir_irq_fsm
    import vir_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic m1_n_i,
    input  logic iorq_n_i,
    input  logic prio_in_i,
    input  logic ret_hit_i,
    output logic int_n_o,
    output logic vec_oe_o,
    output logic prio_out_o
);
    irq_state_t st_q, st_d;
    logic held_q, held_d;
    logic ack;

    assign ack = !m1_n_i && !iorq_n_i;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            held_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            held_q <= held_d;
        end
    end

    // next state
    always_comb begin
        st_d   = st_q;
        held_d = held_q;
        unique case (st_q)
            ST_IDLE: if (evt_i) st_d = ST_PEND;                         // evt_seen
            ST_PEND: if (ack && prio_in_i) st_d = ST_ACK;               // ack_won
            ST_ACK: begin
                if (evt_i) held_d = 1'b1;
                if (!ack) st_d = ST_SERV;                               // ack_done
            end
            ST_SERV: begin
                if (evt_i) held_d = 1'b1;
                if (ret_hit_i && prio_in_i) begin
                    st_d   = (held_q || evt_i) ? ST_PEND : ST_IDLE;     // ret_repend / ret_idle
                    held_d = 1'b0;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        int_n_o    = 1'b1;
        vec_oe_o   = 1'b0;
        prio_out_o = 1'b0;
        unique case (st_q)
            ST_IDLE: prio_out_o = prio_in_i;
            ST_PEND: begin
                int_n_o  = 1'b0;
                vec_oe_o = ack && prio_in_i;
            end
            ST_ACK:  vec_oe_o = ack;
            ST_SERV: ;
            default: ;
        endcase
    end

    // R5: the interrupt line is released once the acknowledge is won
    assert_int_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_oe_o && !int_n_o) |=> int_n_o);
    // R8: the chain is blocked while the responder is busy
    assert_chain_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_IDLE) |-> !prio_out_o);
    // R7: a stretched acknowledge keeps the vector enabled
    assert_ack_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_oe_o && ack) |=> (ack -> vec_oe_o));
    // R9: service ends only through a recognized return
    assert_service_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SERV && !(ret_hit_i && prio_in_i)) |=> (st_q == ST_SERV));
    // R4: the vector is enabled only while both strobes are low
    assert_oe_needs_both_R4: assert property (@(posedge clk) disable iff (!rst_n)
        vec_oe_o |-> (!m1_n_i && !iorq_n_i));
endmodule

// File: rtl/vec_irq_responder.sv
module vec_irq_responder #(
    parameter int         DW      = 8,
    parameter bit         EVEN_ONLY = 1'b1,
    parameter logic [7:0] PFX_OP  = 8'hED,
    parameter logic [7:0] RET_OP  = 8'h4D
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          evt_i,
    input  logic          vec_wr_i,
    input  logic [DW-1:0] vec_wdata_i,
    input  logic          m1_n_i,
    input  logic          iorq_n_i,
    input  logic [DW-1:0] bus_data_i,
    input  logic          prio_in_i,
    output logic          prio_out_o,
    output logic          int_n_o,
    output logic [DW-1:0] vec_o,
    output logic          vec_oe_o
);
    localparam logic [DW-1:0] PFX_W = DW'(PFX_OP);
    localparam logic [DW-1:0] RET_W = DW'(RET_OP);

    logic [DW-1:0] vec_reg;
    logic          ret_hit;

    vir_vector_reg #(.VEC_W(DW), .EVEN_ONLY(EVEN_ONLY)) u_vec (
        .clk(clk), .rst_n(rst_n), .wr_i(vec_wr_i),
        .wdata_i(vec_wdata_i), .vec_o(vec_reg)
    );

    vir_ret_matcher #(.DW(DW), .PFX_OP(PFX_W), .RET_OP(RET_W)) u_ret (
        .clk(clk), .rst_n(rst_n), .m1_n_i(m1_n_i), .iorq_n_i(iorq_n_i),
        .data_i(bus_data_i), .ret_hit_o(ret_hit)
    );

    vir_irq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i),
        .m1_n_i(m1_n_i), .iorq_n_i(iorq_n_i), .prio_in_i(prio_in_i),
        .ret_hit_i(ret_hit), .int_n_o(int_n_o), .vec_oe_o(vec_oe_o),
        .prio_out_o(prio_out_o)
    );

    assign vec_o = vec_oe_o ? vec_reg : '0;

    // R2: the bus byte is quiet unless enabled
    assert_vec_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_oe_o |-> (vec_o == '0));
endmodule

// File: tb/test_vec_irq_responder.sv
module test_vec_irq_responder;
    logic       clk = 1'b0;
    logic       rst_n, evt, vwr, m1_n, iorq_n, pin;
    logic [7:0] vwd, bdata;
    logic       pout, int_n, oe;
    logic [7:0] vec;
    int         n_run = 0, n_fail = 0;

    always #10 clk = ~clk;

    vec_irq_responder i_vec_irq_responder (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .vec_wr_i(vwr), .vec_wdata_i(vwd),
        .m1_n_i(m1_n), .iorq_n_i(iorq_n), .bus_data_i(bdata), .prio_in_i(pin),
        .prio_out_o(pout), .int_n_o(int_n), .vec_o(vec), .vec_oe_o(oe)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic pulse_evt();
        evt = 1'b1; tick(); evt = 1'b0;
    endtask

    task automatic fetch(input logic [7:0] b);
        m1_n = 1'b0; bdata = b; tick();
        m1_n = 1'b1; bdata = 8'h00; tick();
    endtask

    task automatic t_reset();
        rst_n = 1'b0; evt = 0; vwr = 0; vwd = 0; m1_n = 1; iorq_n = 1; bdata = 0; pin = 1;
        repeat (3) tick();
        rst_n = 1'b1; tick(); #1;
        chk(int_n == 1'b1, "R1 int_n", int_n, 1);
        chk(oe == 1'b0, "R1 oe", oe, 0);
        chk(pout == 1'b1, "R1 prio_out", pout, 1);
    endtask

    task automatic t_write_and_event();
        vwr = 1'b1; vwd = 8'h37; tick(); vwr = 1'b0;
        pulse_evt(); #1;
        chk(int_n == 1'b0, "R3 int asserted", int_n, 0);
        chk(pout == 1'b0, "R8 chain blocked when pending", pout, 0);
        chk(vec == 8'h00, "R2 vec quiet", vec, 0);
    endtask

    task automatic t_single_strobes();
        m1_n = 1'b0; bdata = 8'h00; #1;
        chk(oe == 1'b0, "R4 m1 alone", oe, 0);
        tick(); m1_n = 1'b1;
        iorq_n = 1'b0; #1;
        chk(oe == 1'b0, "R4 iorq alone", oe, 0);
        tick(); iorq_n = 1'b1; tick(); #1;
        chk(int_n == 1'b0, "R4 request kept", int_n, 0);
    endtask

    task automatic t_blocked_ack();
        pin = 1'b0; m1_n = 1'b0; iorq_n = 1'b0; #1;
        chk(oe == 1'b0, "R6 no oe without priority", oe, 0);
        tick(); tick(); m1_n = 1'b1; iorq_n = 1'b1; tick(); #1;
        chk(int_n == 1'b0, "R6 still pending", int_n, 0);
        pin = 1'b1;
    endtask

    task automatic t_stretched_ack(input int waits, input logic [7:0] exp_vec);
        m1_n = 1'b0; iorq_n = 1'b0; #1;
        chk(oe == 1'b1, "R5 oe in ack", oe, 1);
        chk(vec == exp_vec, "R2 even vector on bus", vec, exp_vec);
        for (int k = 0; k < waits; k++) begin
            tick(); #1;
            chk(oe == 1'b1, "R7 oe held over wait", oe, 1);
            chk(int_n == 1'b1, "R5 int released", int_n, 1);
        end
        tick(); m1_n = 1'b1; iorq_n = 1'b1; #1;
        chk(oe == 1'b0, "R7 oe drops at end", oe, 0);
        tick(); #1;
        chk(pout == 1'b0, "R8 chain blocked in service", pout, 0);
    endtask

    task automatic t_broken_return();
        fetch(8'hED); fetch(8'h00); fetch(8'h4D); #1;
        chk(pout == 1'b0, "R10 broken sequence ignored", pout, 0);
    endtask

    task automatic t_return_no_prio();
        pin = 1'b0;
        fetch(8'hED); fetch(8'h4D);
        pin = 1'b1; #1;
        chk(pout == 1'b0, "R11 return without priority ignored", pout, 0);
    endtask

    task automatic t_return();
        fetch(8'hED); fetch(8'h4D); #1;
        chk(pout == 1'b1, "R9 return clears service", pout, 1);
        chk(int_n == 1'b1, "R9 no new request", int_n, 1);
    endtask

    task automatic t_event_in_service();
        pulse_evt();
        t_stretched_ack(1, 8'h36);
        pulse_evt(); #1;
        chk(int_n == 1'b1, "R12 held during service", int_n, 1);
        fetch(8'hED); fetch(8'h4D); #1;
        chk(int_n == 1'b0, "R12 held event re-raised", int_n, 0);
        chk(pout == 1'b0, "R12 chain blocked again", pout, 0);
    endtask

    initial begin
        #3_000_000;
        n_fail++; n_run++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_write_and_event();
        t_single_strobes();
        t_blocked_ack();
        t_stretched_ack(3, 8'h36);
        t_broken_return();
        t_return_no_prio();
        t_return();
        t_event_in_service();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule